// File: doc/BRIEF.md
# Serial GPIO Expander Scan Engine

This block adds up to 64 general-purpose outputs and 64 general-purpose inputs to a host. It does this through two external chains of shift registers. Outputs go through a serial-in, parallel-out chain that has an output latch. Inputs come from a parallel-load, serial-out chain. Only four pins are used: serial data out, serial data in, a shift clock and one load/shift strobe that both chains share. The block runs from the bus clock. It divides that clock down to make the shift clock.

Software writes output bytes, one per 8-bit port, and reads input snapshot bytes, one per port. A configuration byte sets how many ports are active in each direction. A select field sets the shift clock rate. Two control bits choose the scan behaviour: an enable bit and a periodic bit. When periodic is set, frames repeat for as long as the block is enabled. When periodic is clear, the block runs a single frame each time it is enabled.

Each frame has two parts. First the strobe is held low for one shift-clock period. This latches the previous frame's outputs and parallel-loads the inputs. Then the strobe goes high and the block shifts enough bits to cover the longer of the two chains. The input snapshot is committed all at once, and a one-cycle done pulse marks the commit.

Top module: `serial_io_expander`

## Requirements
- R1: After a synchronous reset the pins are in these states: `sclk` low, `load_n` high, `sdo` low, `frame_done` low. Every input snapshot byte reads as 0.
- R2: `port_cfg[7:4]` is the active output port count O and `port_cfg[3:0]` is the active input port count I. A nibble value above 8 is treated as 8.
- R3: A frame starts with `load_n` low and `sclk` low for two half-periods. `load_n` then returns high and exactly N = 8·max(O,I) rising `sclk` pulses follow.
- R4: A `div_sel` value s in 0..5 gives an `sclk` half-period of 2^s bus cycles. The values 6 and 7 behave as 5, which gives 32 cycles.
- R5: `sdo` changes only while `sclk` is low. The frame sends N−8·O zero bits first. It then sends output port O−1 bit 7 first, down to port 0 bit 0. After the next strobe rise, latch stage k of the output chain holds bit k of the write bytes (byte p covers bits 8p..8p+7).
- R6: `sdi` is sampled as `sclk` rises. The first bit sampled is input port I−1 bit 7. Snapshot byte p for p < I equals the chain's parallel inputs 8p..8p+7 as they were when the strobe was low.
- R7: Snapshot bytes change only at the edge that raises `frame_done`. Bytes at index ≥ I keep their value, and when I = 0 all bytes keep their value.
- R8: When O = 0, `sdo` stays low for the whole frame.
- R9: With `enable` and `periodic` both set, frames repeat. Clearing `enable` during a frame lets that frame finish, and no further frame starts.
- R10: With `periodic` clear, exactly one frame runs each time `enable` is held high. A new frame needs `enable` to go low and then high again.
- R11: `frame_done` is high for exactly one bus cycle per completed frame.
- R12: A bus cycle with `wr_en` high stores `wr_data` into output byte `wr_port`. `rd_data` shows snapshot byte `rd_port` one cycle after `rd_port` is applied. Output bytes are captured when a frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Scan enable |
| periodic | input | 1 | 1: frames repeat; 0: one frame per enable |
| port_cfg | input | 8 | Output port count in the upper nibble, input port count in the lower nibble |
| div_sel | input | 3 | Shift clock divider select |
| wr_en | input | 1 | Write strobe for an output byte |
| wr_port | input | 3 | Output port index for a write |
| wr_data | input | 8 | Output byte value |
| rd_port | input | 3 | Snapshot port index for a read |
| rd_data | output | 8 | Snapshot byte, registered |
| sdo | output | 1 | Serial data to the output chain |
| sdi | input | 1 | Serial data from the input chain |
| sclk | output | 1 | Shift clock |
| load_n | output | 1 | Shared latch / parallel-load strobe, active low |
| frame_done | output | 1 | One-cycle pulse when a frame has been committed |

## Verification
The hardest situation to reach from the ports is a frame in which the input pins change after the strobe has gone high. The snapshot must still show the values from the strobe-low time, and no byte may change before the done pulse. The bench builds this case directly. It uses a slow divider and a one-shot frame, waits for the strobe to rise, and only then alters the modelled input pins. While the long shift phase runs it reads a port several times, then checks every byte after the pulse. Behavioural models of both external chains close the loop. Every output and input count from 0 to 8, plus nibble values above 8, is swept against those models.

// File: rtl/sx_pkg.sv
package sx_pkg;
  localparam int SX_LANE = 8;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SHIFT, ST_DONE} sx_state_t;
endpackage

// File: rtl/sx_tick.sv
module sx_tick #(
  parameter int DIV_OPTS = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [2:0] sel,
  output logic       tick
);
  localparam int CNTW = DIV_OPTS;

  logic [CNTW-1:0] cnt;
  logic [CNTW-1:0] lim;
  logic [2:0]      sel_c;

  always_comb begin
    sel_c = (sel > 3'(DIV_OPTS - 1)) ? 3'(DIV_OPTS - 1) : sel;
    lim   = (CNTW'(1) << sel_c) - CNTW'(1);
  end

  assign tick = run && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + CNTW'(1);
  end
endmodule

// File: rtl/sx_port_bank.sv
module sx_port_bank import sx_pkg::*; #(
  parameter int PORTS = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [$clog2(PORTS)-1:0]   wr_port,
  input  logic [7:0]                 wr_data,
  input  logic [$clog2(PORTS)-1:0]   rd_port,
  output logic [7:0]                 rd_data,
  input  logic                       upd,
  input  logic [PORTS-1:0]           upd_mask,
  input  logic [PORTS*SX_LANE-1:0]   upd_val,
  output logic [PORTS*SX_LANE-1:0]   wr_flat,
  output logic [PORTS*SX_LANE-1:0]   rd_flat
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_flat <= '0;
      rd_flat <= '0;
      rd_data <= '0;
    end else begin
      for (int p = 0; p < PORTS; p++) begin
        if (wr_en && (int'(wr_port) == p)) wr_flat[p*SX_LANE +: SX_LANE] <= wr_data;
        if (upd && upd_mask[p])
          rd_flat[p*SX_LANE +: SX_LANE] <= upd_val[p*SX_LANE +: SX_LANE];
      end
      rd_data <= rd_flat[int'(rd_port)*SX_LANE +: SX_LANE];
    end
  end
endmodule

// File: rtl/sx_frame_seq.sv
module sx_frame_seq import sx_pkg::*; #(
  parameter int PORTS = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         enable,
  input  logic                         periodic,
  input  logic [7:0]                   cfg,
  input  logic [2:0]                   div_sel,
  input  logic [PORTS*SX_LANE-1:0]     wr_flat,
  input  logic                         sdi,
  input  logic                         tick,
  output logic                         run,
  output logic [2:0]                   sel_q,
  output logic                         sclk,
  output logic                         load_n,
  output logic                         sdo,
  output logic                         frame_done,
  output logic                         upd,
  output logic [PORTS-1:0]             upd_mask,
  output logic [PORTS*SX_LANE-1:0]     upd_val,
  output logic [$clog2(PORTS+1)-1:0]   oc_q
);
  localparam int BITS = PORTS * SX_LANE;
  localparam int CW   = $clog2(BITS + 1);
  localparam int PCW  = $clog2(PORTS + 1);

  function automatic logic [PCW-1:0] clamp_cnt(input logic [3:0] n);
    return (int'(n) > PORTS) ? PCW'(PORTS) : PCW'(n);
  endfunction

  function automatic logic [BITS-1:0] lane_mask(input logic [PCW-1:0] n);
    logic [BITS-1:0] m;
    for (int p = 0; p < PORTS; p++)
      m[p*SX_LANE +: SX_LANE] = (p < int'(n)) ? {SX_LANE{1'b1}} : {SX_LANE{1'b0}};
    return m;
  endfunction

  sx_state_t       st;
  logic            ph;
  logic            shot;
  logic [CW-1:0]   bcnt, nbits;
  logic [PCW-1:0]  ic_q;
  logic [BITS-1:0] out_sh, in_sh;

  logic [PCW-1:0]  oc_n, ic_n, mx_n;
  logic [CW-1:0]   nb_n;
  logic [BITS-1:0] out_n;

  always_comb begin
    oc_n  = clamp_cnt(cfg[7:4]);
    ic_n  = clamp_cnt(cfg[3:0]);
    mx_n  = (oc_n > ic_n) ? oc_n : ic_n;
    nb_n  = CW'(mx_n) << 3;
    out_n = (wr_flat & lane_mask(oc_n)) << (BITS - int'(nb_n));
    for (int p = 0; p < PORTS; p++) upd_mask[p] = (p < int'(ic_q));
    upd_val = in_sh >> (int'(nbits) - (int'(ic_q) << 3));
  end

  assign run = (st == ST_LOAD) || (st == ST_SHIFT);
  assign upd = (st == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; ph <= 1'b0; shot <= 1'b0;
      bcnt <= '0; nbits <= '0; oc_q <= '0; ic_q <= '0; sel_q <= '0;
      out_sh <= '0; in_sh <= '0;
      sclk <= 1'b0; load_n <= 1'b1; sdo <= 1'b0; frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (!enable) shot <= 1'b0;
      unique case (st)
        ST_IDLE: if (enable && (periodic || !shot)) begin
          oc_q   <= oc_n;
          ic_q   <= ic_n;
          nbits  <= nb_n;
          sel_q  <= div_sel;
          out_sh <= out_n;
          load_n <= 1'b0;
          ph     <= 1'b0;
          st     <= ST_LOAD;
        end
        ST_LOAD: if (tick) begin
          if (!ph) ph <= 1'b1;
          else begin
            ph     <= 1'b0;
            load_n <= 1'b1;
            bcnt   <= '0;
            if (nbits == '0) st <= ST_DONE;
            else begin
              st     <= ST_SHIFT;
              sdo    <= out_sh[BITS-1];
              out_sh <= out_sh << 1;
            end
          end
        end
        ST_SHIFT: if (tick) begin
          if (!ph) begin
            ph    <= 1'b1;
            sclk  <= 1'b1;
            in_sh <= {in_sh[BITS-2:0], sdi};
          end else begin
            ph   <= 1'b0;
            sclk <= 1'b0;
            if (bcnt == nbits - CW'(1)) begin
              st  <= ST_DONE;
              sdo <= 1'b0;
            end else begin
              bcnt   <= bcnt + CW'(1);
              sdo    <= out_sh[BITS-1];
              out_sh <= out_sh << 1;
            end
          end
        end
        ST_DONE: begin
          st         <= ST_IDLE;
          frame_done <= 1'b1;
          shot       <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_io_expander.sv
module serial_io_expander import sx_pkg::*; #(
  parameter int PORTS    = 8,
  parameter int DIV_OPTS = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      enable,
  input  logic                      periodic,
  input  logic [7:0]                port_cfg,
  input  logic [2:0]                div_sel,
  input  logic                      wr_en,
  input  logic [$clog2(PORTS)-1:0]  wr_port,
  input  logic [7:0]                wr_data,
  input  logic [$clog2(PORTS)-1:0]  rd_port,
  output logic [7:0]                rd_data,
  output logic                      sdo,
  input  logic                      sdi,
  output logic                      sclk,
  output logic                      load_n,
  output logic                      frame_done
);
  localparam int BITS = PORTS * SX_LANE;
  localparam int PCW  = $clog2(PORTS + 1);

  logic            tick, run, upd;
  logic [2:0]      sel_q;
  logic [PORTS-1:0] upd_mask;
  logic [BITS-1:0] upd_val, wr_flat, rd_flat;
  logic [PCW-1:0]  oc_q;

  sx_tick #(.DIV_OPTS(DIV_OPTS)) u_tick (
    .clk(clk), .rst(rst), .run(run), .sel(sel_q), .tick(tick)
  );

  sx_frame_seq #(.PORTS(PORTS)) u_seq (
    .clk(clk), .rst(rst), .enable(enable), .periodic(periodic),
    .cfg(port_cfg), .div_sel(div_sel), .wr_flat(wr_flat), .sdi(sdi),
    .tick(tick), .run(run), .sel_q(sel_q), .sclk(sclk), .load_n(load_n),
    .sdo(sdo), .frame_done(frame_done), .upd(upd), .upd_mask(upd_mask),
    .upd_val(upd_val), .oc_q(oc_q)
  );

  sx_port_bank #(.PORTS(PORTS)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_port(wr_port), .wr_data(wr_data),
    .rd_port(rd_port), .rd_data(rd_data), .upd(upd), .upd_mask(upd_mask),
    .upd_val(upd_val), .wr_flat(wr_flat), .rd_flat(rd_flat)
  );
endmodule

// File: rtl/sx_checker.sv
module sx_checker #(
  parameter int PORTS = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       sclk,
  input logic                       load_n,
  input logic                       sdo,
  input logic                       frame_done,
  input logic [PORTS*8-1:0]         rd_flat,
  input logic [$clog2(PORTS+1)-1:0] oc_q
);
  // R11: done is a single-cycle pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  // R3: shift clock stays low while the strobe is low
  p_load_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !load_n |-> !sclk);

  // R3: a frame ends with the strobe high and the clock low
  p_done_idle_r3: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (load_n && !sclk));

  // R7: snapshot bytes only move together with the done pulse
  p_rd_atomic_r7: assert property (@(posedge clk) disable iff (rst)
    !frame_done |-> $stable(rd_flat));

  // R8: no output ports means a quiet data line
  p_sdo_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (oc_q == '0) |-> !sdo);

  // R5: data line moves only while the clock is low
  p_sdo_phase_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdo) |-> !sclk);
endmodule

bind serial_io_expander sx_checker #(.PORTS(PORTS)) u_chk (
  .clk(clk), .rst(rst), .sclk(sclk), .load_n(load_n), .sdo(sdo),
  .frame_done(frame_done), .rd_flat(rd_flat), .oc_q(oc_q)
);

// File: tb/sim_serial_io_expander.sv
module sim_serial_io_expander;
  logic       clk = 1'b0, rst = 1'b1, enable = 1'b0, periodic = 1'b1, wr_en = 1'b0;
  logic [7:0] port_cfg = '0, wr_data = '0, rd_data;
  logic [2:0] div_sel = '0, wr_port = '0, rd_port = '0;
  logic       sdo, sdi, sclk, load_n, frame_done;

  int total = 0, bad = 0;
  int o_eff = 0, i_eff = 0, sdo_err = 0, done_cnt = 0;
  logic [63:0] och = '0, olat = '0, ich = '0, pins = '0, wr_img = '0;
  logic [7:0]  exp_rd [8];

  always #5 clk = ~clk;

  serial_io_expander u0 (
    .clk(clk), .rst(rst), .enable(enable), .periodic(periodic),
    .port_cfg(port_cfg), .div_sel(div_sel), .wr_en(wr_en), .wr_port(wr_port),
    .wr_data(wr_data), .rd_port(rd_port), .rd_data(rd_data), .sdo(sdo),
    .sdi(sdi), .sclk(sclk), .load_n(load_n), .frame_done(frame_done)
  );

  // external chain models; an unused input chain drives 1 to prove it is ignored
  assign sdi = (i_eff == 0) ? 1'b1 : ich[i_eff*8-1];
  always @(posedge sclk) begin
    #1;
    och = {och[62:0], sdo};
    if (load_n) ich = {ich[62:0], 1'b0};
  end
  always @(negedge load_n) begin #1; ich = pins; end
  always @(posedge load_n) olat = och;

  always @(negedge clk) begin
    if (frame_done) done_cnt++;
    if (sdo && o_eff == 0) sdo_err++;
  end

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #1500000;
    total++; bad++;
    $display("FAIL watchdog R9 actual=timeout expected=completion");
    summary();
    $finish;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int clampn(input int n);
    return (n > 8) ? 8 : n;
  endfunction

  function automatic logic [63:0] bmask(input int n);
    return (n == 0) ? 64'd0 : ({64{1'b1}} >> (64 - n*8));
  endfunction

  task automatic write_port(input int p, input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_port = 3'(p); wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    wr_img[p*8 +: 8] = v;
  endtask

  task automatic read_port(input int p, output logic [7:0] v);
    @(negedge clk);
    rd_port = 3'(p);
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!frame_done);
  endtask

  task automatic run_combo(input int oraw, input int iraw);
    int o = clampn(oraw);
    int i = clampn(iraw);
    logic [7:0] v;
    for (int p = 0; p < 8; p++) write_port(p, 8'((oraw*37 + iraw*11 + p*73 + 5) & 255));
    for (int p = 0; p < 8; p++) pins[p*8 +: 8] = 8'(((oraw*53 + iraw*29 + p*17 + 200) & 255) ^ 8'h5A);
    @(negedge clk);
    port_cfg = {4'(oraw), 4'(iraw)};
    o_eff = o; i_eff = i; sdo_err = 0;
    periodic = 1'b1; enable = 1'b1;
    wait_done();
    wait_done();
    enable = 1'b0;
    for (int p = 0; p < i; p++) exp_rd[p] = pins[p*8 +: 8];
    if (o > 0) begin
      if (oraw > 8) chk("R2 output count clamp", olat & bmask(o), wr_img & bmask(o));
      else          chk("R5/R12 output latch", olat & bmask(o), wr_img & bmask(o));
    end
    for (int p = 0; p < 8; p++) begin
      read_port(p, v);
      if (iraw > 8)    chk("R2 input count clamp", 64'(v), 64'(exp_rd[p]));
      else if (p < i)  chk("R6 input snapshot", 64'(v), 64'(exp_rd[p]));
      else             chk("R7 inactive byte kept", 64'(v), 64'(exp_rd[p]));
    end
    if (o == 0) chk("R8 sdo low with no outputs", 64'(sdo_err), 64'd0);
  endtask

  task automatic div_test(input int sel);
    int lo = 0, hi = 0, rises = 0, h;
    logic prev = 1'b0;
    h = 1 << ((sel > 5) ? 5 : sel);
    @(negedge clk);
    div_sel = 3'(sel); port_cfg = 8'h10; o_eff = 1; i_eff = 0;
    periodic = 1'b0; enable = 1'b1;
    do begin
      @(negedge clk);
      if (!load_n) lo++;
      if (sclk && !prev) rises++;
      if (sclk && rises == 1) hi++;
      prev = sclk;
    end while (!frame_done);
    enable = 1'b0;
    chk("R4 sclk high half-period", 64'(hi), 64'(h));
    chk("R3 strobe low length", 64'(lo), 64'(2*h));
    chk("R3 pulse count", 64'(rises), 64'd8);
  endtask

  initial begin
    logic [7:0] v;
    int c0, lowafter, dbl;
    bit seen;
    for (int p = 0; p < 8; p++) exp_rd[p] = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 sclk", 64'(sclk), 64'd0);
    chk("R1 load_n", 64'(load_n), 64'd1);
    chk("R1 sdo", 64'(sdo), 64'd0);
    chk("R1 frame_done", 64'(frame_done), 64'd0);
    for (int p = 0; p < 8; p++) begin
      read_port(p, v);
      chk("R1 snapshot zero", 64'(v), 64'd0);
    end

    // R4/R3 divider sweep, including clamped selects
    for (int s = 0; s < 8; s++) div_test(s);

    // sweep of all port counts plus out-of-range nibbles
    div_sel = 3'd0;
    for (int o = 0; o < 10; o++)
      for (int i = 0; i < 10; i++)
        run_combo((o == 9) ? 12 : o, (i == 9) ? 15 : i);

    // R7: pins change after the strobe; snapshot stays put until done
    @(negedge clk);
    pins = 64'h0123_4567_89AB_CDEF;
    port_cfg = 8'h08; o_eff = 0; i_eff = 8; div_sel = 3'd2;
    periodic = 1'b0; enable = 1'b1;
    do @(negedge clk); while (load_n);
    do @(negedge clk); while (!load_n);
    pins = 64'hFEDC_BA98_7654_3210;
    for (int k = 0; k < 5; k++) begin
      repeat (40) @(negedge clk);
      read_port(3, v);
      chk("R7 no early update", 64'(v), 64'(exp_rd[3]));
    end
    wait_done();
    enable = 1'b0;
    for (int p = 0; p < 8; p++) begin
      exp_rd[p] = 8'(64'h0123_4567_89AB_CDEF >> (p*8));
      read_port(p, v);
      chk("R7 snapshot from strobe time", 64'(v), 64'(exp_rd[p]));
    end

    // R10: one frame per enable in one-shot mode
    @(negedge clk);
    div_sel = 3'd0; port_cfg = 8'h11; o_eff = 1; i_eff = 1;
    periodic = 1'b0; c0 = done_cnt; enable = 1'b1;
    repeat (600) @(negedge clk);
    chk("R10 single frame", 64'(done_cnt - c0), 64'd1);
    enable = 1'b0;
    repeat (3) @(negedge clk);
    c0 = done_cnt; enable = 1'b1;
    repeat (600) @(negedge clk);
    chk("R10 re-armed frame", 64'(done_cnt - c0), 64'd1);
    enable = 1'b0;
    repeat (3) @(negedge clk);

    // R9/R11: periodic frames, then stop at frame end
    port_cfg = 8'h88; o_eff = 8; i_eff = 8; periodic = 1'b1;
    c0 = done_cnt; enable = 1'b1;
    repeat (400) @(negedge clk);
    chk("R9 frames repeat", 64'(done_cnt - c0 >= 2), 64'd1);
    do @(negedge clk); while (load_n);
    do @(negedge clk); while (!load_n);
    repeat (20) @(negedge clk);
    enable = 1'b0;
    c0 = done_cnt; lowafter = 0; dbl = 0; seen = 1'b0;
    for (int k = 0; k < 500; k++) begin
      @(negedge clk);
      if (seen && !load_n) lowafter++;
      if (frame_done) begin
        if (seen) dbl++;
        seen = 1'b1;
      end else seen = seen;
      if (frame_done) begin
        @(negedge clk);
        if (frame_done) dbl++;
        if (!load_n) lowafter++;
      end
    end
    chk("R9 current frame finishes", 64'(done_cnt - c0), 64'd1);
    chk("R9 no frame after disable", 64'(lowafter), 64'd0);
    chk("R11 single-cycle pulse", 64'(dbl), 64'd0);

    summary();
    $finish;
  end
endmodule